// File: doc/BRIEF.md
# Frame Data Buffer with Auto-Incrementing Port

This block sits between an 8-bit host bus and a frame-oriented core. It has two 16-word buffers, one for each direction. Transmit frames go from the host to the core and receive frames go from the core to the host. The host reaches each buffer through a single data port. An internal word counter chooses the word that is accessed, so the host never drives a word address. Each 16-bit word crosses the bus as two byte accesses: the low byte first, then the high byte. Only the high-byte access moves the counter on.

The core side works with whole frames. A push loads a complete receive frame in one cycle and raises a ready flag for the host. If the host has not finished reading the previous frame, the push replaces it. A pull takes the last complete transmit frame the host wrote. If no new frame has arrived since the previous pull, the core receives the same frame again, and a freshness flag tells it that this is a replay. The frame length is programmable from 1 to 16 words.

With DMA mode enabled, per-direction request lines are raised. Transfers are then qualified by active-low acknowledge lines instead of the chip select. A flush, issued for a stop or idle command, empties both directions.

Top module: `fb_frame_buf`

## Requirements
- R1: After reset, `rx_ready_o`, `core_tx_fresh_o`, both request lines and every bit of `core_tx_frame_o` are 0.
- R2: A qualified transmit-port write with `byte_hi_i`=0 stores the low byte. A qualified write with `byte_hi_i`=1 then completes the word at the current counter index, as {high, low}, and advances the counter.
- R3: When the high byte of word `flen_m1_i` is written, the transmit frame becomes complete and the counter returns to word 0. The next pull shows the frame on `core_tx_frame_o`, with word k at bits [16k+15:16k], one cycle after the pull, and `core_tx_fresh_o` is high for that one cycle only.
- R4: A pull made when no new complete transmit frame exists leaves `core_tx_frame_o` unchanged and gives `core_tx_fresh_o`=0. `core_tx_frame_o` changes only on a pull or a flush.
- R5: A core push loads `core_rx_frame_i`, sets `rx_ready_o` the next cycle and resets the receive counter to word 0. `rdata_o` shows the low byte (`byte_hi_i`=0) or the high byte (`byte_hi_i`=1) of the word at the counter.
- R6: Only a qualified high-byte read advances the receive counter. The high-byte read of word `flen_m1_i` clears `rx_ready_o` and returns the counter to word 0.
- R7: A push while a frame is partly read replaces that frame, and the next read starts at word 0 of the new frame.
- R8: `flush_i` clears `rx_ready_o`, any pending transmit frame, both counters, the stored low byte and `core_tx_frame_o` (to 0).
- R9: With `dma_en_i`=1, `tx_dreq_o` is high while no complete transmit frame is pending and `rx_dreq_o` equals `rx_ready_o`. Accesses are qualified by `tx_dack_ni`/`rx_dack_ni` low, and `cs_ni` is ignored. With `dma_en_i`=0 both requests are 0.
- R10: Strobes without qualification have no effect. This covers `cs_ni`=1 in host mode and the matching acknowledge high in DMA mode.
- R11: The frame length is `flen_m1_i`+1 words, for every value from 1 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty both directions (stop/idle) |
| dma_en_i | input | 1 | DMA mode select |
| flen_m1_i | input | 4 | Frame length minus one, in words |
| cs_ni | input | 1 | Host chip select, active low |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| port_rx_i | input | 1 | Port select: 0 transmit, 1 receive |
| byte_hi_i | input | 1 | Byte select: 0 low, 1 high |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Receive byte at the current counter |
| tx_dack_ni | input | 1 | Transmit DMA acknowledge, active low |
| rx_dack_ni | input | 1 | Receive DMA acknowledge, active low |
| tx_dreq_o | output | 1 | Transmit DMA request |
| rx_dreq_o | output | 1 | Receive DMA request |
| rx_ready_o | output | 1 | Complete receive frame available |
| core_tx_pull_i | input | 1 | Core takes a transmit frame |
| core_tx_frame_o | output | 256 | Frame given to the core |
| core_tx_fresh_o | output | 1 | Last pull delivered a new frame |
| core_rx_push_i | input | 1 | Core delivers a receive frame |
| core_rx_frame_i | input | 256 | Receive frame from the core |

## Verification
The assertions check the following flag relations on every cycle: a push sets the ready flag, and the ready flag holds its value unless a push, read or flush comes. The frame given to the core moves only on a pull or a flush, freshness is a one-cycle answer to a pull, a flush clears everything, and the request lines follow their mode and flags. Only the bench scenarios can show that data arrives right. That covers byte assembly order, counter wrap at each programmed length, word placement in the frame vector, overwrite of a half-read frame, the content of a replayed frame, and ignored strobes.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned FB_WORDS = 16;
  localparam int unsigned FB_DW    = 16;

  typedef enum logic {
    PORT_TX = 1'b0,
    PORT_RX = 1'b1
  } fb_port_e;
endpackage

// File: rtl/fb_port_ctr.sv
module fb_port_ctr #(
  parameter int unsigned WORDS = 16,
  localparam int unsigned IW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [IW-1:0] last_i,
  output logic [IW-1:0] idx_o,
  output logic          wrap_o
);
  logic [IW-1:0] idx_q;

  // >= keeps the counter bounded if the length shrinks mid-frame
  assign wrap_o = adv_i && (idx_q >= last_i);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (wrap_o) idx_q <= '0;
    else if (adv_i)  idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/fb_tx_path.sv
module fb_tx_path #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW = $clog2(WORDS),
  localparam int unsigned BW = DW / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                acc_i,
  input  logic                hi_i,
  input  logic [BW-1:0]       wdata_i,
  input  logic [IW-1:0]       last_i,
  input  logic                pull_i,
  output logic                full_o,
  output logic [WORDS*DW-1:0] frame_o,
  output logic                fresh_o
);
  logic [DW-1:0] mem_q  [WORDS];
  logic [DW-1:0] held_q [WORDS];
  logic [BW-1:0] stage_q;
  logic [IW-1:0] idx;
  logic          adv, wrap, full_q, fresh_q;

  assign adv = acc_i && hi_i;

  fb_port_ctr #(.WORDS(WORDS)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (flush_i),
    .adv_i (adv),
    .last_i(last_i),
    .idx_o (idx),
    .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      full_q  <= 1'b0;
      fresh_q <= 1'b0;
      for (int k = 0; k < WORDS; k++) begin
        mem_q[k]  <= '0;
        held_q[k] <= '0;
      end
    end else if (flush_i) begin
      stage_q <= '0;
      full_q  <= 1'b0;
      fresh_q <= 1'b0;
      for (int k = 0; k < WORDS; k++) begin
        mem_q[k]  <= '0;
        held_q[k] <= '0;
      end
    end else begin
      if (acc_i && !hi_i) stage_q <= wdata_i;
      if (adv) mem_q[idx] <= {wdata_i, stage_q};
      // pull samples the registered buffer; a frame completing now stays pending
      if (pull_i && full_q)
        for (int k = 0; k < WORDS; k++) held_q[k] <= mem_q[k];
      fresh_q <= pull_i && full_q;
      full_q  <= (full_q && !pull_i) || wrap;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_pack
    assign frame_o[g*DW +: DW] = held_q[g];
  end

  assign full_o  = full_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/fb_rx_path.sv
module fb_rx_path #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW = $clog2(WORDS),
  localparam int unsigned BW = DW / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                acc_i,
  input  logic                hi_i,
  input  logic [IW-1:0]       last_i,
  input  logic                push_i,
  input  logic [WORDS*DW-1:0] frame_i,
  output logic                ready_o,
  output logic [BW-1:0]       rdata_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic [IW-1:0] idx;
  logic          adv, wrap, ready_q;

  // reads of an empty buffer do not move the counter
  assign adv = acc_i && hi_i && ready_q && !push_i;

  fb_port_ctr #(.WORDS(WORDS)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (flush_i || push_i),
    .adv_i (adv),
    .last_i(last_i),
    .idx_o (idx),
    .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      for (int k = 0; k < WORDS; k++) mem_q[k] <= '0;
    end else if (flush_i) begin
      ready_q <= 1'b0;
      for (int k = 0; k < WORDS; k++) mem_q[k] <= '0;
    end else if (push_i) begin
      ready_q <= 1'b1;
      for (int k = 0; k < WORDS; k++) mem_q[k] <= frame_i[k*DW +: DW];
    end else if (wrap) begin
      ready_q <= 1'b0;
    end
  end

  assign ready_o = ready_q;
  assign rdata_o = hi_i ? mem_q[idx][DW-1:BW] : mem_q[idx][BW-1:0];
endmodule

// File: rtl/fb_frame_buf.sv
module fb_frame_buf
  import fb_pkg::*;
#(
  parameter int unsigned WORDS = FB_WORDS,
  parameter int unsigned DW    = FB_DW,
  localparam int unsigned IW = $clog2(WORDS),
  localparam int unsigned BW = DW / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                dma_en_i,
  input  logic [IW-1:0]       flen_m1_i,
  input  logic                cs_ni,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic                port_rx_i,
  input  logic                byte_hi_i,
  input  logic [BW-1:0]       wdata_i,
  output logic [BW-1:0]       rdata_o,
  input  logic                tx_dack_ni,
  input  logic                rx_dack_ni,
  output logic                tx_dreq_o,
  output logic                rx_dreq_o,
  output logic                rx_ready_o,
  input  logic                core_tx_pull_i,
  output logic [WORDS*DW-1:0] core_tx_frame_o,
  output logic                core_tx_fresh_o,
  input  logic                core_rx_push_i,
  input  logic [WORDS*DW-1:0] core_rx_frame_i
);
  logic tx_acc, rx_acc, tx_full, rx_ready;

  always_comb begin
    if (dma_en_i) begin
      tx_acc = wr_i && !tx_dack_ni;
      rx_acc = rd_i && !rx_dack_ni;
    end else begin
      tx_acc = wr_i && !cs_ni && (fb_port_e'(port_rx_i) == PORT_TX);
      rx_acc = rd_i && !cs_ni && (fb_port_e'(port_rx_i) == PORT_RX);
    end
  end

  fb_tx_path #(.WORDS(WORDS), .DW(DW)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .acc_i  (tx_acc),
    .hi_i   (byte_hi_i),
    .wdata_i(wdata_i),
    .last_i (flen_m1_i),
    .pull_i (core_tx_pull_i),
    .full_o (tx_full),
    .frame_o(core_tx_frame_o),
    .fresh_o(core_tx_fresh_o)
  );

  fb_rx_path #(.WORDS(WORDS), .DW(DW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .acc_i  (rx_acc),
    .hi_i   (byte_hi_i),
    .last_i (flen_m1_i),
    .push_i (core_rx_push_i),
    .frame_i(core_rx_frame_i),
    .ready_o(rx_ready),
    .rdata_o(rdata_o)
  );

  assign rx_ready_o = rx_ready;
  assign tx_dreq_o  = dma_en_i && !tx_full;
  assign rx_dreq_o  = dma_en_i && rx_ready;
endmodule

// File: rtl/fb_frame_buf_chk.sv
module fb_frame_buf_chk #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned DW    = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                flush_i,
  input logic                dma_en_i,
  input logic                rd_i,
  input logic                tx_dreq_o,
  input logic                rx_dreq_o,
  input logic                rx_ready_o,
  input logic                core_tx_pull_i,
  input logic [WORDS*DW-1:0] core_tx_frame_o,
  input logic                core_tx_fresh_o,
  input logic                core_rx_push_i
);
  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rx_push_i && !flush_i |=> rx_ready_o); // R5
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rx_push_i && !rd_i && !flush_i |=> $stable(rx_ready_o)); // R6
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_tx_pull_i && !flush_i |=> $stable(core_tx_frame_o)); // R4
  AST_FRESH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_tx_pull_i |=> !core_tx_fresh_o); // R3
  AST_FLUSH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !rx_ready_o && !core_tx_fresh_o && (core_tx_frame_o == '0)); // R8
  AST_DREQ_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> !tx_dreq_o && !rx_dreq_o); // R9
  AST_RX_DREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dreq_o |-> rx_ready_o); // R9
endmodule

bind fb_frame_buf fb_frame_buf_chk #(.WORDS(WORDS), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .dma_en_i       (dma_en_i),
  .rd_i           (rd_i),
  .tx_dreq_o      (tx_dreq_o),
  .rx_dreq_o      (rx_dreq_o),
  .rx_ready_o     (rx_ready_o),
  .core_tx_pull_i (core_tx_pull_i),
  .core_tx_frame_o(core_tx_frame_o),
  .core_tx_fresh_o(core_tx_fresh_o),
  .core_rx_push_i (core_rx_push_i)
);

// File: tb/sim_fb_frame_buf.sv
module sim_fb_frame_buf;
  localparam int WORDS = 16;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 0, dma_en = 0, cs_n = 1, rd = 0, wr = 0, prx = 0, bhi = 0;
  logic [3:0] flen_m1 = '0;
  logic [7:0] wdata = '0, rdata;
  logic tx_dack_n = 1, rx_dack_n = 1, tx_dreq, rx_dreq, rx_ready;
  logic pull = 0, push = 0, fresh;
  logic [WORDS*DW-1:0] tx_frame, rx_frame = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fb_frame_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .dma_en_i(dma_en),
    .flen_m1_i(flen_m1), .cs_ni(cs_n), .rd_i(rd), .wr_i(wr),
    .port_rx_i(prx), .byte_hi_i(bhi), .wdata_i(wdata), .rdata_o(rdata),
    .tx_dack_ni(tx_dack_n), .rx_dack_ni(rx_dack_n), .tx_dreq_o(tx_dreq),
    .rx_dreq_o(rx_dreq), .rx_ready_o(rx_ready), .core_tx_pull_i(pull),
    .core_tx_frame_o(tx_frame), .core_tx_fresh_o(fresh),
    .core_rx_push_i(push), .core_rx_frame_i(rx_frame)
  );

  function automatic logic [15:0] txw(int l, int k);
    return 16'hA000 ^ 16'(l << 8) ^ 16'(k * 17) ^ 16'h0040;
  endfunction
  function automatic logic [15:0] rxw(int l, int k);
    return 16'h3C00 ^ 16'(l << 9) ^ 16'(k * 16'h0111) ^ 16'h0005;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one byte access; qual asserts cs (host mode) or the matching ack (DMA mode)
  task automatic xfer(bit is_wr, bit rx, bit hi, logic [7:0] d, bit qual,
                      output logic [7:0] q);
    @(negedge clk);
    wr = is_wr; rd = !is_wr; prx = rx; bhi = hi; wdata = d;
    cs_n      = !(qual && !dma_en);
    tx_dack_n = !(qual && dma_en && !rx);
    rx_dack_n = !(qual && dma_en && rx);
    #1 q = rdata;
    @(negedge clk);
    wr = 0; rd = 0; cs_n = 1; tx_dack_n = 1; rx_dack_n = 1;
  endtask

  task automatic wr_word(logic [15:0] w, bit qual);
    logic [7:0] q;
    xfer(1, 0, 0, w[7:0], qual, q);
    xfer(1, 0, 1, w[15:8], qual, q);
  endtask

  task automatic rd_word(output logic [15:0] w, input bit qual);
    logic [7:0] lo, hi;
    xfer(0, 1, 0, 8'h00, qual, lo);
    xfer(0, 1, 1, 8'h00, qual, hi);
    w = {hi, lo};
  endtask

  task automatic do_pull();
    @(negedge clk); pull = 1;
    @(negedge clk); pull = 0;
  endtask

  task automatic do_push(int l);
    for (int k = 0; k < WORDS; k++) rx_frame[k*DW +: DW] = rxw(l, k);
    @(negedge clk); push = 1;
    @(negedge clk); push = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!rx_ready && !fresh && !tx_dreq && !rx_dreq && tx_frame == '0, "R1",
        {rx_ready, fresh, tx_dreq, rx_dreq}, 0);

    // R11 sweep over every frame length
    for (int l = 1; l <= WORDS; l++) begin
      @(negedge clk); flen_m1 = 4'(l - 1);
      // R2 R3 transmit frame
      for (int k = 0; k < l; k++) wr_word(txw(l, k), 1);
      do_pull();
      chk(fresh, "R3", fresh, 1);
      for (int k = 0; k < l; k++)
        chk(tx_frame[k*DW +: DW] == txw(l, k), "R2", tx_frame[k*DW +: DW], txw(l, k));
      @(negedge clk);
      chk(!fresh, "R3", fresh, 0);
      // R4 replay
      do_pull();
      chk(!fresh, "R4", fresh, 0);
      for (int k = 0; k < l; k++)
        chk(tx_frame[k*DW +: DW] == txw(l, k), "R4", tx_frame[k*DW +: DW], txw(l, k));
      // R5 R6 receive frame
      do_push(l);
      chk(rx_ready, "R5", rx_ready, 1);
      for (int k = 0; k < l; k++) begin
        chk(rx_ready, "R6", rx_ready, 1);
        rd_word(w, 1);
        chk(w == rxw(l, k), "R5", w, rxw(l, k));
      end
      chk(!rx_ready, "R6", rx_ready, 0);
    end

    // R7 overwrite of a half-read frame
    @(negedge clk); flen_m1 = 4'd3;
    do_push(20);
    rd_word(w, 1); rd_word(w, 1);
    do_push(21);
    for (int k = 0; k < 4; k++) begin
      rd_word(w, 1);
      chk(w == rxw(21, k), "R7", w, rxw(21, k));
    end
    chk(!rx_ready, "R7", rx_ready, 0);

    // R10 unqualified strobes ignored
    @(negedge clk); flen_m1 = 4'd0;
    wr_word(16'h1234, 0);
    do_pull();
    chk(!fresh, "R10", fresh, 0);
    do_push(22);
    rd_word(w, 0);
    chk(rx_ready, "R10", rx_ready, 1);
    xfer(1, 1, 1, 8'hEE, 1, q);   // write aimed at receive port
    rd_word(w, 1);
    chk(w == rxw(22, 0), "R10", w, rxw(22, 0));

    // R8 flush mid-transfer
    @(negedge clk); flen_m1 = 4'd1;
    do_push(23);
    xfer(1, 0, 0, 8'h77, 1, q);
    xfer(1, 0, 1, 8'h66, 1, q);
    rd_word(w, 1);
    do_flush();
    chk(!rx_ready && tx_frame == '0, "R8", rx_ready, 0);
    wr_word(16'hBEEF, 1);
    wr_word(16'hCAFE, 1);
    do_pull();
    chk(fresh && tx_frame[15:0] == 16'hBEEF, "R8", tx_frame[15:0], 16'hBEEF);
    chk(tx_frame[31:16] == 16'hCAFE, "R8", tx_frame[31:16], 16'hCAFE);

    // R9 DMA mode
    @(negedge clk); dma_en = 1; flen_m1 = 4'd2;
    @(negedge clk);
    chk(tx_dreq && !rx_dreq, "R9", {tx_dreq, rx_dreq}, 2);
    wr_word(16'h0F0F, 0);
    chk(tx_dreq, "R10", tx_dreq, 1);
    for (int k = 0; k < 3; k++) wr_word(txw(30, k), 1);
    chk(!tx_dreq, "R9", tx_dreq, 0);
    do_pull();
    chk(tx_dreq && fresh, "R9", {tx_dreq, fresh}, 3);
    chk(tx_frame[47:32] == txw(30, 2), "R9", tx_frame[47:32], txw(30, 2));
    do_push(31);
    chk(rx_dreq, "R9", rx_dreq, 1);
    for (int k = 0; k < 3; k++) begin
      rd_word(w, 1);
      chk(w == rxw(31, k), "R9", w, rxw(31, k));
    end
    chk(!rx_dreq && !rx_ready, "R9", rx_dreq, 0);
    @(negedge clk); dma_en = 0;
    @(negedge clk);
    chk(!tx_dreq && !rx_dreq, "R9", {tx_dreq, rx_dreq}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule